// File: doc/BRIEF.md
# Processor Cache Line State Controller

This block is the processor-side agent of a directory-based coherence scheme. It holds a small direct-mapped cache in which each line carries a coherence state, an address tag and a data word. Coherence messages arrive on a single message port. A fill installs a line, and its subtype picks the state. An invalidate removes a line. A commit retires one outstanding read. A lookup port returns, one cycle later, the state, hit flag, data and an "unmodified" flag for any address.

The block also tracks outstanding commits. Each issued read adds one commit that is owed, and each commit message pays one back. A memory-barrier request is held until nothing is owed. The block then answers with a one-cycle done pulse. Because barrier completion waits on commit messages, data returns can overtake it. A commit with nothing owed saturates the counter at zero and sets a sticky error flag.

Top module: `line_state_ctrl`

## Requirements
- R1: After reset every line is Invalid, every lookup misses with state 0, the outstanding count is zero, and `mb_done` and `cnt_err` are low.
- R2: A fill (`msg_type`=0) with subtype 0 installs the line as Shared (state 1). The index is the low `INDEX_W` address bits. The tag is taken from the remaining address bits and the data word from `msg_data`.
- R3: A fill with subtype 3 installs the line as Exclusive clean (state 2). A fill with subtype 1 (modify) installs it as Exclusive dirty (state 3).
- R4: A fill with subtype 2 (fetch) leaves the line's state, tag and data unchanged.
- R5: An invalidate (`msg_type`=1) makes the addressed line Invalid when the line is valid with a matching tag. If the tag differs, the line is left as it was.
- R6: `lk_unmod` is high exactly when the lookup hits a line in state 1 or 2. On a miss, `lk_hit` and `lk_unmod` are 0 and `lk_state` reads 0.
- R7: An install to an index that holds a different tag replaces that line, so the old address then misses.
- R8: Each cycle with `rd_issue` adds one to the outstanding count, and each commit (`msg_type`=2) subtracts one. A read and a commit in the same cycle leave the count unchanged. Message type 3 is ignored.
- R9: A barrier request is held until the outstanding count, as registered at a clock edge, is zero. The following cycle carries a single one-cycle `mb_done` pulse.
- R10: A commit arriving with a zero count and no read in that cycle leaves the count at zero and sets `cnt_err`. The flag stays set until reset.
- R11: Lookup outputs are registered. They show the array contents as they stood at the edge that samples `lk_addr`, so an install at that same edge becomes visible one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_type | input | 2 | 0 fill, 1 invalidate, 2 commit, 3 ignored |
| msg_sub | input | 2 | Fill subtype: 0 shared, 1 modify, 2 fetch, 3 exclusive |
| msg_addr | input | ADDR_W | Message line address |
| msg_data | input | DATA_W | Fill data |
| rd_issue | input | 1 | A read was issued this cycle (one commit owed) |
| mb_req | input | 1 | Memory-barrier request strobe |
| lk_addr | input | ADDR_W | Lookup address |
| lk_state | output | 2 | Looked-up line state (0 on a miss) |
| lk_hit | output | 1 | Lookup hit |
| lk_unmod | output | 1 | Looked-up line is unmodified |
| lk_data | output | DATA_W | Looked-up data (meaningful on a hit) |
| mb_done | output | 1 | Barrier completion pulse |
| cnt_err | output | 1 | Sticky commit-underflow flag |

## Verification
Some properties are checked on every cycle. A done pulse only follows a zero count, a read and commit in the same cycle hold the count, underflow saturates and latches the error flag, and a miss never reports a state or an unmodified flag. Other behaviour only the directed scenarios can show. These cover which state each fill subtype installs, that a fetch fill and a mismatched invalidate leave a line untouched, eviction on index conflict, the one-cycle lookup latency, and how long a barrier is held while commits are owed.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2,
    LN_DRT = 2'd3
  } line_st_e;

  localparam logic [1:0] MT_FILL   = 2'd0;
  localparam logic [1:0] MT_INVAL  = 2'd1;
  localparam logic [1:0] MT_COMMIT = 2'd2;

  localparam logic [1:0] FS_SHARED = 2'd0;
  localparam logic [1:0] FS_MOD    = 2'd1;
  localparam logic [1:0] FS_FETCH  = 2'd2;
  localparam logic [1:0] FS_EXCL   = 2'd3;
endpackage

// File: rtl/lsc_msg_decode.sv
module lsc_msg_decode
  import lsc_pkg::*;
(
  input  logic       msg_valid,
  input  logic [1:0] msg_type,
  input  logic [1:0] msg_sub,
  output logic       install,
  output line_st_e   install_st,
  output logic       inval_req,
  output logic       commit
);
  always_comb begin
    install   = msg_valid && (msg_type == MT_FILL) && (msg_sub != FS_FETCH);
    inval_req = msg_valid && (msg_type == MT_INVAL);
    commit    = msg_valid && (msg_type == MT_COMMIT);
    case (msg_sub)
      FS_MOD:  install_st = LN_DRT;
      FS_EXCL: install_st = LN_EXC;
      default: install_st = LN_SHR;
    endcase
  end
endmodule

// File: rtl/lsc_line_array.sv
module lsc_line_array
  import lsc_pkg::*;
#(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               install,
  input  line_st_e           install_st,
  input  logic               inval_req,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [INDEX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0]   lk_tag,
  output line_st_e           lk_state,
  output logic               lk_hit,
  output logic               lk_unmod,
  output logic [DATA_W-1:0]  lk_data
);
  localparam int LINES = 1 << INDEX_W;

  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] mem   [LINES];

  logic inval_match;
  logic lk_match;

  assign inval_match = inval_req && (st_q[wr_idx] != LN_INV) && (tag_q[wr_idx] == wr_tag);
  assign lk_match    = (st_q[lk_idx] != LN_INV) && (tag_q[lk_idx] == lk_tag);

  // state and tag need reset, so they live in registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LN_INV;
        tag_q[i] <= '0;
      end
    end else if (install) begin
      st_q[wr_idx]  <= install_st;
      tag_q[wr_idx] <= wr_tag;
    end else if (inval_match) begin
      st_q[wr_idx] <= LN_INV;
    end
  end

  // data store: no reset, synchronous read, RAM-inferable
  always_ff @(posedge clk) begin
    if (install) mem[wr_idx] <= wr_data;
    lk_data <= mem[lk_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_state <= LN_INV;
      lk_hit   <= 1'b0;
      lk_unmod <= 1'b0;
    end else begin
      lk_state <= lk_match ? st_q[lk_idx] : LN_INV;
      lk_hit   <= lk_match;
      lk_unmod <= lk_match && ((st_q[lk_idx] == LN_SHR) || (st_q[lk_idx] == LN_EXC));
    end
  end
endmodule

// File: rtl/lsc_commit_tracker.sv
module lsc_commit_tracker #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_issue,
  input  logic             commit,
  input  logic             mb_req,
  output logic [CNT_W-1:0] outstanding,
  output logic             mb_done,
  output logic             cnt_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic pend_q;
  logic waiting;
  logic cnt_zero;

  assign waiting  = pend_q || mb_req;
  assign cnt_zero = (outstanding == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= '0;
      cnt_err     <= 1'b0;
    end else if (rd_issue && !commit) begin
      if (outstanding != CNT_MAX) outstanding <= outstanding + 1'b1;
    end else if (commit && !rd_issue) begin
      if (cnt_zero) cnt_err <= 1'b1;
      else          outstanding <= outstanding - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      mb_done <= 1'b0;
    end else begin
      mb_done <= waiting && cnt_zero;
      pend_q  <= waiting && !cnt_zero;
    end
  end
endmodule

// File: rtl/line_state_ctrl.sv
module line_state_ctrl
  import lsc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 3,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msg_valid,
  input  logic [1:0]        msg_type,
  input  logic [1:0]        msg_sub,
  input  logic [ADDR_W-1:0] msg_addr,
  input  logic [DATA_W-1:0] msg_data,
  input  logic              rd_issue,
  input  logic              mb_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic [1:0]        lk_state,
  output logic              lk_hit,
  output logic              lk_unmod,
  output logic [DATA_W-1:0] lk_data,
  output logic              mb_done,
  output logic              cnt_err
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic             install;
  line_st_e         install_st;
  logic             inval_req;
  logic             commit_evt;
  line_st_e         lk_st_e;
  logic [CNT_W-1:0] outstanding;

  lsc_msg_decode u_dec (
    .msg_valid (msg_valid),
    .msg_type  (msg_type),
    .msg_sub   (msg_sub),
    .install   (install),
    .install_st(install_st),
    .inval_req (inval_req),
    .commit    (commit_evt)
  );

  lsc_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_arr (
    .clk       (clk),
    .rst       (rst),
    .install   (install),
    .install_st(install_st),
    .inval_req (inval_req),
    .wr_idx    (msg_addr[INDEX_W-1:0]),
    .wr_tag    (msg_addr[ADDR_W-1:INDEX_W]),
    .wr_data   (msg_data),
    .lk_idx    (lk_addr[INDEX_W-1:0]),
    .lk_tag    (lk_addr[ADDR_W-1:INDEX_W]),
    .lk_state  (lk_st_e),
    .lk_hit    (lk_hit),
    .lk_unmod  (lk_unmod),
    .lk_data   (lk_data)
  );

  assign lk_state = lk_st_e;

  lsc_commit_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk        (clk),
    .rst        (rst),
    .rd_issue   (rd_issue),
    .commit     (commit_evt),
    .mb_req     (mb_req),
    .outstanding(outstanding),
    .mb_done    (mb_done),
    .cnt_err    (cnt_err)
  );
endmodule

// File: rtl/lsc_chk.sv
module lsc_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_issue,
  input logic             commit,
  input logic [CNT_W-1:0] cnt,
  input logic             mb_done,
  input logic             cnt_err,
  input logic             lk_hit,
  input logic             lk_unmod,
  input logic [1:0]       lk_state
);
  // R9
  done_needs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mb_done |-> $past(cnt) == '0);

  // R8
  same_cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_issue && commit) |=> $stable(cnt));

  // R10
  underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !rd_issue && cnt == '0) |=> (cnt_err && cnt == '0));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_err |=> cnt_err);

  // R6
  unmod_hit_chk: assert property (@(posedge clk) disable iff (rst)
    lk_unmod |-> (lk_hit && (lk_state == 2'd1 || lk_state == 2'd2)));

  // R6
  miss_state_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_state == 2'd0 && !lk_unmod));
endmodule

bind line_state_ctrl lsc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_issue(rd_issue),
  .commit  (commit_evt),
  .cnt     (outstanding),
  .mb_done (mb_done),
  .cnt_err (cnt_err),
  .lk_hit  (lk_hit),
  .lk_unmod(lk_unmod),
  .lk_state(lk_state)
);

// File: tb/line_state_ctrl_tb.sv
module line_state_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_type = '0;
  logic [1:0]  msg_sub = '0;
  logic [7:0]  msg_addr = '0;
  logic [15:0] msg_data = '0;
  logic        rd_issue = 1'b0;
  logic        mb_req = 1'b0;
  logic [7:0]  lk_addr = '0;
  logic [1:0]  lk_state;
  logic        lk_hit, lk_unmod, mb_done, cnt_err;
  logic [15:0] lk_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  line_state_ctrl u_dut (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_type(msg_type),
    .msg_sub(msg_sub), .msg_addr(msg_addr), .msg_data(msg_data),
    .rd_issue(rd_issue), .mb_req(mb_req), .lk_addr(lk_addr),
    .lk_state(lk_state), .lk_hit(lk_hit), .lk_unmod(lk_unmod),
    .lk_data(lk_data), .mb_done(mb_done), .cnt_err(cnt_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input logic [1:0] s, input logic [7:0] a, input logic [15:0] d);
    msg_valid = 1'b1; msg_type = t; msg_sub = s; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic look(input string req, input logic [7:0] a, input logic h,
                      input logic [1:0] st, input logic um, input logic [15:0] d);
    lk_addr = a;
    @(negedge clk);
    chk({req, " hit"}, 32'(lk_hit), 32'(h));
    chk({req, " state"}, 32'(lk_state), 32'(st));
    chk({req, " unmod"}, 32'(lk_unmod), 32'(um));
    if (h) chk({req, " data"}, 32'(lk_data), 32'(d));
  endtask

  task automatic t_reset();
    look("R1 reset", 8'h15, 0, 0, 0, 0);
    look("R1 reset", 8'h00, 0, 0, 0, 0);
    chk("R1 mb_done", 32'(mb_done), 0);
    chk("R1 cnt_err", 32'(cnt_err), 0);
  endtask

  task automatic t_fills();
    send(2'd0, 2'd0, 8'h15, 16'hA1A1);
    look("R2 shared fill / R6", 8'h15, 1, 1, 1, 16'hA1A1);
    send(2'd0, 2'd3, 8'h22, 16'hB2B2);
    look("R3 exclusive fill / R6", 8'h22, 1, 2, 1, 16'hB2B2);
    send(2'd0, 2'd1, 8'h23, 16'hC3C3);
    look("R3 modify fill / R6", 8'h23, 1, 3, 0, 16'hC3C3);
  endtask

  task automatic t_fetch();
    send(2'd0, 2'd2, 8'h15, 16'hFFFF);
    look("R4 fetch keeps line", 8'h15, 1, 1, 1, 16'hA1A1);
    send(2'd0, 2'd2, 8'h04, 16'h1234);
    look("R4 fetch no install", 8'h04, 0, 0, 0, 0);
    send(2'd3, 2'd0, 8'h15, 16'h0000);
    look("R8 type 3 ignored", 8'h15, 1, 1, 1, 16'hA1A1);
  endtask

  task automatic t_inval();
    send(2'd1, 2'd0, 8'h35, 16'h0);
    look("R5 tag mismatch ignored", 8'h15, 1, 1, 1, 16'hA1A1);
    send(2'd1, 2'd0, 8'h15, 16'h0);
    look("R5 invalidate", 8'h15, 0, 0, 0, 0);
  endtask

  task automatic t_evict();
    send(2'd0, 2'd0, 8'h63, 16'h6363);
    look("R7 new line", 8'h63, 1, 1, 1, 16'h6363);
    look("R7 old line gone", 8'h23, 0, 0, 0, 0);
  endtask

  task automatic t_latency();
    lk_addr = 8'h17;
    send(2'd0, 2'd3, 8'h17, 16'h7777);
    chk("R11 same-edge lookup sees old", 32'(lk_hit), 0);
    @(negedge clk);
    chk("R11 next lookup hit", 32'(lk_hit), 1);
    chk("R11 next lookup state", 32'(lk_state), 2);
  endtask

  task automatic t_barrier();
    mb_req = 1'b1; @(negedge clk); mb_req = 1'b0;
    chk("R9 immediate done", 32'(mb_done), 1);
    @(negedge clk);
    chk("R9 done one cycle", 32'(mb_done), 0);
    rd_issue = 1'b1; @(negedge clk); @(negedge clk);
    msg_valid = 1'b1; msg_type = 2'd2; @(negedge clk);
    msg_valid = 1'b0; rd_issue = 1'b0;
    mb_req = 1'b1; @(negedge clk); mb_req = 1'b0;
    chk("R8 count two holds barrier", 32'(mb_done), 0);
    repeat (3) begin
      @(negedge clk);
      chk("R9 barrier held", 32'(mb_done), 0);
    end
    send(2'd2, 2'd0, 8'h0, 16'h0);
    chk("R8 one commit owed", 32'(mb_done), 0);
    send(2'd2, 2'd0, 8'h0, 16'h0);
    chk("R9 done follows zero edge", 32'(mb_done), 0);
    @(negedge clk);
    chk("R9 done pulse", 32'(mb_done), 1);
    @(negedge clk);
    chk("R9 pulse ends", 32'(mb_done), 0);
    chk("R10 no error yet", 32'(cnt_err), 0);
  endtask

  task automatic t_underflow();
    send(2'd2, 2'd0, 8'h0, 16'h0);
    chk("R10 underflow flag", 32'(cnt_err), 1);
    mb_req = 1'b1; @(negedge clk); mb_req = 1'b0;
    chk("R10 count stayed zero", 32'(mb_done), 1);
    repeat (2) @(negedge clk);
    chk("R10 flag sticky", 32'(cnt_err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fills();
    t_fetch();
    t_inval();
    t_evict();
    t_latency();
    t_barrier();
    t_underflow();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule